// File: doc/BRIEF.md
# Affine-Gap Alignment Cell Vector

This block scores four cells of a local sequence-alignment matrix in each accepted cycle. The four cells are packed as signed 8-bit lanes of 32-bit words. The lanes lie along an anti-diagonal of a four-column strip: lane k owns column k+1 of the strip. In iteration t (counted from zero after `start`), lane k works on row t-k+1. The cell above a lane's cell is that lane's own previous result. The cell to its left is the previous result of the lane below it. The diagonal cell is that lower lane's result from two iterations back. Lane 0 takes its left and diagonal values from a boundary feed, which is driven either by the top lane of a neighbouring unit or by memory.

Each lane works out a substitution index by comparing its query and reference symbols, then reads the score from a four-entry table. It evaluates the local recursion H = max(0, E, F, Hdiag + S) with saturating adds. The horizontal and vertical gap terms use an opening or an extension penalty, chosen by a per-cell flag that records whether the neighbouring cell's maximum came from a gap term. A small controller tracks the strip with three states: IDLE (no strip open since reset), FILL (lanes coming online one per accepted iteration) and RUN (all lanes active). Its transitions are:
- start: from any state to FILL.
- fill_done: from FILL to RUN, taken on the accept in which the fill counter reaches LANES-1.

Top module: `aln_cellvec`

## Requirements
- R1: While reset is held and after its release, all H, E and F lanes, the gap flags and `out_valid` read zero, and the controller is in IDLE.
- R2: Symbols 0..3 are nucleotide codes and any value above 3 is unknown. The substitution index is:
  - 3 if either symbol is unknown;
  - otherwise 0 if the symbols are equal;
  - otherwise 1 if their bit 0 matches;
  - otherwise 2.
  The score is byte `idx` of `sub_tab` (bits 8*idx+7 .. 8*idx).
- R3: Each lane outputs H = max(0, E, F, sat(Hdiag + S)), so H is never below E, F or zero.
- R4: E = max(E_left, sat(H_left + p_left)) and F = max(F_up, sat(H_up + p_up)), where p is `pen_ext` when the neighbouring cell's gap flag is 1 and `pen_open` otherwise. A cell's gap flag is 1 exactly when max(E, F) is greater than both sat(Hdiag + S) and 0.
- R5: Every add saturates to the signed 8-bit range, so a sum above 127 gives 127 and not a wrapped value.
- R6: Lane k>0 takes its left H, E and flag from lane k-1 one iteration back, and its diagonal H from lane k-1 two iterations back. Lane 0 takes `feed_h`, `feed_e` and `feed_gap` as its left values, and the `feed_h` of the previous accepted iteration as its diagonal (zero for the first iteration after `start`).
- R7: After `start`, lane k outputs all-zero results for iterations 0..k-1. These zeros serve as matrix row 0 for the lanes that follow.
- R8: Results appear one cycle after an accepted `in_valid`, with `out_valid` high for that one cycle. Back-to-back accepts give one result set per cycle.
- R9: A cycle without `in_valid` leaves all outputs and lane state unchanged and drives `out_valid` low.
- R10: Before the first `start`, `in_valid` is ignored: no result appears and the outputs stay zero.
- R11: `start` clears all lane state, the boundary diagonal and the fill counter. It takes priority over `in_valid` in the same cycle, so the next cycle shows zero outputs with `out_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Opens a new strip and clears lane state |
| in_valid | input | 1 | One iteration's inputs are present |
| qry_sym | input | 32 | Query symbol per lane |
| ref_sym | input | 32 | Reference symbol per lane |
| sub_tab | input | 32 | Four signed substitution scores, byte n for index n |
| pen_open | input | 8 | Signed gap-opening penalty |
| pen_ext | input | 8 | Signed gap-extension penalty |
| feed_h | input | 8 | Left H for lane 0 |
| feed_e | input | 8 | Left E for lane 0 |
| feed_gap | input | 1 | Left gap flag for lane 0 |
| h_out | output | 32 | H per lane |
| e_out | output | 32 | E per lane |
| f_out | output | 32 | F per lane |
| gap_out | output | 4 | Gap flag per lane |
| out_valid | output | 1 | Results valid |

## Verification
The bench builds a full reference matrix for each strip and compares every lane of every iteration against it. This catches a diagonal taken from the wrong delay stage or a lane chained to the wrong neighbour, because either one shifts the scores to the wrong rows. Large substitution scores push H to the upper clamp, where a wrapping adder would produce negative values. Ties between the gap and diagonal terms arise often with small random tables, and they expose a flag built with the wrong comparison or a penalty chosen from the wrong neighbour. Idle cycles inside a strip, `start` arriving together with `in_valid`, and traffic before the first `start` show any design that advances state when it should hold.

// File: rtl/aln_pkg.sv
package aln_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_RUN  = 2'd2
    } strip_st_t;

    localparam int SUB_ENTRIES = 4;

endpackage

// File: rtl/aln_subst.sv
module aln_subst #(
    parameter int W = 8
) (
    input  logic [W-1:0]               q_sym,
    input  logic [W-1:0]               d_sym,
    input  logic [aln_pkg::SUB_ENTRIES*W-1:0] tab,
    output logic signed [W-1:0]        score
);
    logic [1:0] idx;
    logic       unk;

    always_comb begin
        unk = (q_sym > W'(3)) || (d_sym > W'(3));
        if (unk)                    idx = 2'd3;
        else if (q_sym == d_sym)    idx = 2'd0;
        else if (q_sym[0] == d_sym[0]) idx = 2'd1;
        else                        idx = 2'd2;
    end

    always_comb begin
        unique case (idx)
            2'd0: score = $signed(tab[0*W +: W]);
            2'd1: score = $signed(tab[1*W +: W]);
            2'd2: score = $signed(tab[2*W +: W]);
            default: score = $signed(tab[3*W +: W]);
        endcase
    end
endmodule

// File: rtl/aln_lane.sv
module aln_lane #(
    parameter int W = 8
) (
    input  logic                       active,
    input  logic [W-1:0]               q_sym,
    input  logic [W-1:0]               d_sym,
    input  logic [aln_pkg::SUB_ENTRIES*W-1:0] tab,
    input  logic signed [W-1:0]        pen_open,
    input  logic signed [W-1:0]        pen_ext,
    input  logic signed [W-1:0]        diag_h,
    input  logic signed [W-1:0]        left_h,
    input  logic signed [W-1:0]        left_e,
    input  logic                       left_gap,
    input  logic signed [W-1:0]        up_h,
    input  logic signed [W-1:0]        up_f,
    input  logic                       up_gap,
    output logic signed [W-1:0]        h_new,
    output logic signed [W-1:0]        e_new,
    output logic signed [W-1:0]        f_new,
    output logic                       gap_new
);
    function automatic logic signed [W-1:0] sadd(input logic signed [W-1:0] a,
                                                 input logic signed [W-1:0] b);
        logic signed [W:0] s;
        s = {a[W-1], a} + {b[W-1], b};
        if (s[W] != s[W-1])
            return s[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
        return s[W-1:0];
    endfunction

    function automatic logic signed [W-1:0] smax(input logic signed [W-1:0] a,
                                                 input logic signed [W-1:0] b);
        return (a > b) ? a : b;
    endfunction

    logic signed [W-1:0] score;
    logic signed [W-1:0] diag_sum, e_cand, f_cand, e_val, f_val, gap_best;

    aln_subst #(.W(W)) u_subst (
        .q_sym (q_sym),
        .d_sym (d_sym),
        .tab   (tab),
        .score (score)
    );

    always_comb begin
        diag_sum = sadd(diag_h, score);
        e_cand   = sadd(left_h, left_gap ? pen_ext : pen_open);
        f_cand   = sadd(up_h, up_gap ? pen_ext : pen_open);
        e_val    = smax(left_e, e_cand);
        f_val    = smax(up_f, f_cand);
        gap_best = smax(e_val, f_val);
        if (active) begin
            e_new   = e_val;
            f_new   = f_val;
            h_new   = smax('0, smax(gap_best, diag_sum));
            gap_new = (gap_best > diag_sum) && (gap_best > $signed(W'(0)));
        end else begin
            e_new   = '0;
            f_new   = '0;
            h_new   = '0;
            gap_new = 1'b0;
        end
    end
endmodule

// File: rtl/aln_ctrl.sv
module aln_ctrl
    import aln_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             in_valid,
    output logic             accept,
    output logic             clear,
    output logic [LANES-1:0] lane_active
);
    localparam int CW = (LANES > 1) ? $clog2(LANES) : 1;

    strip_st_t      state, state_nx;
    logic [CW-1:0]  fill_cnt, fill_cnt_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            fill_cnt <= '0;
        end else begin
            state    <= state_nx;
            fill_cnt <= fill_cnt_nx;
        end
    end

    always_comb begin
        state_nx    = state;
        fill_cnt_nx = fill_cnt;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_nx    = ST_FILL;
                    fill_cnt_nx = '0;
                end
            end
            ST_FILL: begin
                if (start) begin
                    fill_cnt_nx = '0;
                end else if (in_valid) begin
                    if (fill_cnt == CW'(LANES-1)) state_nx = ST_RUN;
                    else fill_cnt_nx = fill_cnt + 1'b1;
                end
            end
            ST_RUN: begin
                if (start) begin
                    state_nx    = ST_FILL;
                    fill_cnt_nx = '0;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        clear  = start;
        accept = in_valid && !start && (state != ST_IDLE);
    end

    for (genvar k = 0; k < LANES; k++) begin : g_act
        assign lane_active[k] = (state == ST_RUN) ||
                                ((state == ST_FILL) && (fill_cnt >= CW'(k)));
    end

    // R7
    fill_to_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_RUN) |-> $past(in_valid) && !$past(start));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !start) |=> state == ST_IDLE);
endmodule

// File: rtl/aln_cellvec.sv
module aln_cellvec
    import aln_pkg::*;
#(
    parameter int W     = 8,
    parameter int LANES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   in_valid,
    input  logic [LANES*W-1:0]     qry_sym,
    input  logic [LANES*W-1:0]     ref_sym,
    input  logic [SUB_ENTRIES*W-1:0] sub_tab,
    input  logic [W-1:0]           pen_open,
    input  logic [W-1:0]           pen_ext,
    input  logic [W-1:0]           feed_h,
    input  logic [W-1:0]           feed_e,
    input  logic                   feed_gap,
    output logic [LANES*W-1:0]     h_out,
    output logic [LANES*W-1:0]     e_out,
    output logic [LANES*W-1:0]     f_out,
    output logic [LANES-1:0]       gap_out,
    output logic                   out_valid
);
    logic             accept, clear;
    logic [LANES-1:0] lane_active;

    logic signed [W-1:0] h_q  [LANES];
    logic signed [W-1:0] hd_q [LANES];
    logic signed [W-1:0] e_q  [LANES];
    logic signed [W-1:0] f_q  [LANES];
    logic [LANES-1:0]    g_q;
    logic signed [W-1:0] feed_h_q;

    logic signed [W-1:0] h_nx [LANES];
    logic signed [W-1:0] e_nx [LANES];
    logic signed [W-1:0] f_nx [LANES];
    logic [LANES-1:0]    g_nx;

    aln_ctrl #(.LANES(LANES)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .in_valid    (in_valid),
        .accept      (accept),
        .clear       (clear),
        .lane_active (lane_active)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic signed [W-1:0] l_h, l_e, d_h;
        logic                l_g;
        if (k == 0) begin : g_edge
            assign l_h = $signed(feed_h);
            assign l_e = $signed(feed_e);
            assign l_g = feed_gap;
            assign d_h = feed_h_q;
        end else begin : g_chain
            assign l_h = h_q[k-1];
            assign l_e = e_q[k-1];
            assign l_g = g_q[k-1];
            assign d_h = hd_q[k-1];
        end

        aln_lane #(.W(W)) u_lane (
            .active   (lane_active[k]),
            .q_sym    (qry_sym[k*W +: W]),
            .d_sym    (ref_sym[k*W +: W]),
            .tab      (sub_tab),
            .pen_open ($signed(pen_open)),
            .pen_ext  ($signed(pen_ext)),
            .diag_h   (d_h),
            .left_h   (l_h),
            .left_e   (l_e),
            .left_gap (l_g),
            .up_h     (h_q[k]),
            .up_f     (f_q[k]),
            .up_gap   (g_q[k]),
            .h_new    (h_nx[k]),
            .e_new    (e_nx[k]),
            .f_new    (f_nx[k]),
            .gap_new  (g_nx[k])
        );

        assign h_out[k*W +: W] = h_q[k];
        assign e_out[k*W +: W] = e_q[k];
        assign f_out[k*W +: W] = f_q[k];

        // R3
        h_dominates_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (h_q[k] >= e_q[k]) && (h_q[k] >= f_q[k]) &&
                          (h_q[k] >= $signed(W'(0))));

        // R4
        gap_positive_chk: assert property (@(posedge clk) disable iff (!rst_n)
            g_q[k] |-> h_q[k] > $signed(W'(0)));
    end

    assign gap_out = g_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < LANES; k++) begin
                h_q[k]  <= '0;
                hd_q[k] <= '0;
                e_q[k]  <= '0;
                f_q[k]  <= '0;
            end
            g_q       <= '0;
            feed_h_q  <= '0;
            out_valid <= 1'b0;
        end else if (clear) begin
            for (int k = 0; k < LANES; k++) begin
                h_q[k]  <= '0;
                hd_q[k] <= '0;
                e_q[k]  <= '0;
                f_q[k]  <= '0;
            end
            g_q       <= '0;
            feed_h_q  <= '0;
            out_valid <= 1'b0;
        end else if (accept) begin
            for (int k = 0; k < LANES; k++) begin
                h_q[k]  <= h_nx[k];
                hd_q[k] <= h_q[k];
                e_q[k]  <= e_nx[k];
                f_q[k]  <= f_nx[k];
            end
            g_q       <= g_nx;
            feed_h_q  <= $signed(feed_h);
            out_valid <= 1'b1;
        end else begin
            out_valid <= 1'b0;
        end
    end

    // R8
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid) && !$past(start));

    // R9
    hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid || start) |=> $stable(h_out) && $stable(e_out) &&
                                 $stable(f_out) && $stable(gap_out) && !out_valid);

    // R11
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (h_out == '0) && (e_out == '0) && (gap_out == '0) && !out_valid);
endmodule

// File: tb/aln_cellvec_tb.sv
module aln_cellvec_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NR = 40;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        start = 0;
    logic        in_valid = 0;
    logic [31:0] qry_sym = 0, ref_sym = 0, sub_tab = 0;
    logic [7:0]  pen_open = 0, pen_ext = 0, feed_h = 0, feed_e = 0;
    logic        feed_gap = 0;
    logic [31:0] h_out, e_out, f_out;
    logic [3:0]  gap_out;
    logic        out_valid;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    int Q [0:NR];
    int D [0:4];
    int HC [0:NR];
    int EC [0:NR];
    int GC [0:NR];
    int mh [0:NR][0:4];
    int me [0:NR][0:4];
    int mf [0:NR][0:4];
    int mg [0:NR][0:4];
    int tb_tab [0:3];
    int p_open, p_ext;

    always #(CLK_PERIOD/2) clk = ~clk;

    aln_cellvec u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
        .qry_sym(qry_sym), .ref_sym(ref_sym), .sub_tab(sub_tab),
        .pen_open(pen_open), .pen_ext(pen_ext), .feed_h(feed_h),
        .feed_e(feed_e), .feed_gap(feed_gap), .h_out(h_out), .e_out(e_out),
        .f_out(f_out), .gap_out(gap_out), .out_valid(out_valid)
    );

    function automatic int sat(int a);
        if (a > 127) return 127;
        if (a < -128) return -128;
        return a;
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int sub_score(int q, int d);
        if (q > 3 || d > 3) return tb_tab[3];
        if (q == d) return tb_tab[0];
        if ((q % 2) == (d % 2)) return tb_tab[1];
        return tb_tab[2];
    endfunction

    function automatic int lane_s(logic [31:0] w, int k);
        logic signed [7:0] b;
        b = w[k*8 +: 8];
        return int'(b);
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic build_model();
        for (int j = 0; j <= 4; j++) begin
            mh[0][j] = 0; me[0][j] = 0; mf[0][j] = 0; mg[0][j] = 0;
        end
        for (int i = 1; i <= NR; i++) begin
            for (int j = 1; j <= 4; j++) begin
                int lh, le, lg, dh, ev, fv, ds, m;
                lh = (j == 1) ? HC[i] : mh[i][j-1];
                le = (j == 1) ? EC[i] : me[i][j-1];
                lg = (j == 1) ? GC[i] : mg[i][j-1];
                dh = (j == 1) ? HC[i-1] : mh[i-1][j-1];
                ev = imax(le, sat(lh + (lg != 0 ? p_ext : p_open)));
                fv = imax(mf[i-1][j], sat(mh[i-1][j] + (mg[i-1][j] != 0 ? p_ext : p_open)));
                ds = sat(dh + sub_score(Q[i], D[j]));
                m  = imax(ev, fv);
                me[i][j] = ev;
                mf[i][j] = fv;
                mg[i][j] = (m > ds && m > 0) ? 1 : 0;
                mh[i][j] = imax(0, imax(m, ds));
            end
        end
    endtask

    task automatic load_cfg();
        sub_tab  = {tb_tab[3][7:0], tb_tab[2][7:0], tb_tab[1][7:0], tb_tab[0][7:0]};
        pen_open = p_open[7:0];
        pen_ext  = p_ext[7:0];
    endtask

    task automatic pulse_start(bit with_valid);
        @(negedge clk);
        start = 1; in_valid = with_valid;
        @(negedge clk);
        start = 0; in_valid = 0;
    endtask

    task automatic run_strip(bit sat_mode);
        string tag;
        HC[0] = 0; EC[0] = 0; GC[0] = 0; Q[0] = 0; D[0] = 0;
        for (int i = 1; i <= NR; i++) begin
            Q[i]  = $urandom_range(5);
            HC[i] = sat_mode ? $urandom_range(127) : $urandom_range(40);
            EC[i] = $urandom_range(HC[i]);
            GC[i] = $urandom_range(1);
        end
        for (int j = 1; j <= 4; j++) D[j] = $urandom_range(5);
        if (sat_mode) begin
            tb_tab[0] = 120; tb_tab[1] = 100; tb_tab[2] = 90; tb_tab[3] = 110;
            p_open = -3; p_ext = -1;
        end else begin
            for (int n = 0; n < 4; n++) tb_tab[n] = int'($urandom_range(20)) - 8;
            p_open = -int'($urandom_range(6)) - 1;
            p_ext  = -int'($urandom_range(2));
        end
        load_cfg();
        build_model();
        pulse_start(0);
        ref_sym = {D[4][7:0], D[3][7:0], D[2][7:0], D[1][7:0]};
        for (int t = 0; t < NR; t++) begin
            if ($urandom_range(3) == 0) begin
                logic [31:0] hs;
                hs = h_out;
                @(negedge clk);
                in_valid = 0; feed_h = 8'($urandom); qry_sym = $urandom;
                @(negedge clk);
                check(h_out == hs && !out_valid, "R9", "idle cycle hold", int'(out_valid), 0);
            end
            @(negedge clk);
            in_valid = 1;
            for (int k = 0; k < 4; k++)
                qry_sym[k*8 +: 8] = (t - k + 1 >= 1) ? Q[t-k+1][7:0] : 8'd0;
            feed_h = HC[t+1][7:0]; feed_e = EC[t+1][7:0]; feed_gap = GC[t+1][0];
            @(negedge clk);
            in_valid = 0;
            check(out_valid, "R8", "out_valid after accept", int'(out_valid), 1);
            for (int k = 0; k < 4; k++) begin
                int r, eh, ee, ef, eg;
                r = t - k + 1;
                eh = (r >= 1) ? mh[r][k+1] : 0;
                ee = (r >= 1) ? me[r][k+1] : 0;
                ef = (r >= 1) ? mf[r][k+1] : 0;
                eg = (r >= 1) ? mg[r][k+1] : 0;
                if (r < 1) tag = "R7";
                else if (sat_mode) tag = "R5 R3";
                else if (k == 0) tag = "R6 R3 R4";
                else tag = "R6 R4 R3";
                check(lane_s(h_out, k) == eh, tag, $sformatf("H lane %0d iter %0d", k, t), lane_s(h_out, k), eh);
                check(lane_s(e_out, k) == ee, tag, $sformatf("E lane %0d iter %0d", k, t), lane_s(e_out, k), ee);
                check(lane_s(f_out, k) == ef, tag, $sformatf("F lane %0d iter %0d", k, t), lane_s(f_out, k), ef);
                check(int'(gap_out[k]) == eg, tag, $sformatf("gap lane %0d iter %0d", k, t), int'(gap_out[k]), eg);
            end
        end
    endtask

    task automatic direct_subst(int q, int d, int exp);
        pulse_start(0);
        @(negedge clk);
        in_valid = 1;
        qry_sym = {24'd0, q[7:0]}; ref_sym = {24'd0, d[7:0]};
        feed_h = 0; feed_e = 0; feed_gap = 0;
        @(negedge clk);
        in_valid = 0;
        check(lane_s(h_out, 0) == exp, "R2", $sformatf("score q=%0d d=%0d", q, d), lane_s(h_out, 0), exp);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        check(h_out == 0 && e_out == 0 && f_out == 0 && gap_out == 0 && !out_valid,
              "R1", "reset outputs", int'(out_valid), 0);
        rst_n = 1;
        @(negedge clk);
        check(h_out == 0 && !out_valid, "R1", "after reset release", int'(h_out), 0);

        // R10: traffic before any start
        tb_tab[0] = 50; tb_tab[1] = 50; tb_tab[2] = 50; tb_tab[3] = 50;
        p_open = -2; p_ext = -1;
        load_cfg();
        @(negedge clk);
        in_valid = 1; qry_sym = 32'h01010101; ref_sym = 32'h01010101; feed_h = 8'd30;
        @(negedge clk);
        check(!out_valid && h_out == 0, "R10", "idle ignores in_valid", int'(h_out), 0);
        @(negedge clk);
        in_valid = 0;
        check(!out_valid && h_out == 0, "R10", "idle ignores second", int'(out_valid), 0);

        // R2 substitution lookup
        tb_tab[0] = 11; tb_tab[1] = 22; tb_tab[2] = 33; tb_tab[3] = 44;
        p_open = -1; p_ext = -1;
        load_cfg();
        direct_subst(2, 2, 11);
        direct_subst(0, 2, 22);
        direct_subst(1, 2, 33);
        direct_subst(5, 1, 44);
        direct_subst(3, 9, 44);

        run_strip(0);
        run_strip(0);
        run_strip(1);

        // R11: start together with in_valid mid-strip
        @(negedge clk);
        in_valid = 1; qry_sym = 32'h02020202; feed_h = 8'd20;
        @(negedge clk);
        start = 1; in_valid = 1;
        @(negedge clk);
        start = 0; in_valid = 0;
        check(h_out == 0 && e_out == 0 && f_out == 0 && !out_valid,
              "R11", "start clears and wins", int'(h_out), 0);
        run_strip(0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule